// File: doc/BRIEF.md
# Deep Low-Power Mode Sequencer

This block steps a processor subsystem into its deepest sleep mode and back out, in a fixed order. Entry starts when the core signals wait-for-interrupt and the sleep configuration selects the deep mode. The block then waits for the bus and the memory controller to go idle. It asks the external DRAM to enter self-refresh, masks the clocks, and turns off the PLLs. Last, it turns off the main oscillator. The 32.768 kHz oscillator stays on at all times.

A wakeup reverses the order. The main oscillator is enabled and given a settle time taken from a programmable count. The PLLs are then enabled and given a lock time from a second count. After that the clocks are unmasked and self-refresh is released. A done pulse marks the return to the running state.

The block runs on the always-on clock, so its wait counters keep working while the PLLs are off. Two options are latched when entry starts: whether the top logic domain stays powered, and whether the L2 RAM keeps its contents. An interrupt-block option holds back the interrupt to the core while a sequence is in progress. A wakeup that arrives during entry is remembered and acted on once the fully-off state is reached.

Top module: `pms_top`

## Requirements
- R1: Entry starts on the edge after `wfi_i` is high with `cfg_standby_i` == 2'b10 and `cfg_core_on_i` low. With any other standby value, or with `cfg_core_on_i` high, the block stays in the running state.
- R2: The block leaves the bus-drain step only while `bus_idle_i` is high. It leaves the memory-drain step only while `mem_idle_i` is high. It leaves the self-refresh request step only while `sr_ack_i` is high.
- R3: Once self-refresh is acknowledged, the block takes one cycle for each of these steps, in order: mask the clocks, turn off the PLLs, turn off the main oscillator. `osc32k_en_o` is 1 at all times.
- R4: In the fully-off state, `core_pwr_o` is 0. `top_pwr_o` equals `cfg_top_on_i` and `l2_pwr_o` equals `cfg_l2_keep_i`, both as sampled in the cycle entry started; later changes to these inputs have no effect. In every other state all three power enables are 1.
- R5: In the fully-off state a high `wake_i` starts exit on the next edge. Without a wakeup the block stays in the fully-off state. A `wake_i` pulse seen in the running state is ignored.
- R6: A `wake_i` pulse during entry (states 1 to 6) is held. The fully-off state then lasts exactly one cycle.
- R7: The oscillator-settle state lasts `osc_cnt_i`+1 cycles. During it the oscillator is enabled, the PLLs are off and the clocks are masked.
- R8: The PLL-lock state lasts `pll_cnt_i`+1 cycles. During it the PLLs are enabled and the clocks are still masked.
- R9: After PLL lock, the block spends one cycle with the clocks unmasked while self-refresh is still requested. It then drops `sr_req_o` and waits until `sr_ack_i` is low. On that edge it returns to the running state and raises `done_o` for exactly one cycle.
- R10: `irq_o` follows `irq_i`, except that it is forced low while `cfg_irq_block_i` is high and the state is not the running state.
- R11: `state_o` encoding:
  - 0 = run
  - 1 = bus drain
  - 2 = memory drain
  - 3 = self-refresh request
  - 4 = clock mask
  - 5 = PLL off
  - 6 = oscillator off
  - 7 = fully off
  - 8 = oscillator settle
  - 9 = PLL lock
  - 10 = clock unmask
  - 11 = self-refresh exit
- R12: After reset the block is in the running state with all enables set and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| wfi_i | input | 1 | Core is waiting for interrupt |
| cfg_standby_i | input | 2 | Standby-on-WFI selection; 2'b10 selects deep mode |
| cfg_core_on_i | input | 1 | Keep core logic on; blocks deep entry |
| cfg_top_on_i | input | 1 | Keep top domain powered in deep mode |
| cfg_l2_keep_i | input | 1 | Keep L2 RAM powered for retention |
| cfg_irq_block_i | input | 1 | Block the interrupt while sequencing |
| irq_i | input | 1 | Interrupt from the power controller |
| bus_idle_i | input | 1 | Bus transactions drained |
| mem_idle_i | input | 1 | Memory-controller transactions drained |
| sr_ack_i | input | 1 | DRAM self-refresh acknowledge |
| wake_i | input | 1 | Wakeup request |
| osc_cnt_i | input | CNT_W | Oscillator settle count |
| pll_cnt_i | input | CNT_W | PLL lock count |
| osc_en_o | output | 1 | Main oscillator enable |
| osc32k_en_o | output | 1 | 32.768 kHz oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| clk_mask_o | output | 1 | Clock mask to clock-on blocks |
| sr_req_o | output | 1 | DRAM self-refresh request |
| core_pwr_o | output | 1 | Core domain power enable |
| top_pwr_o | output | 1 | Top domain power enable |
| l2_pwr_o | output | 1 | L2 RAM power enable |
| irq_o | output | 1 | Gated interrupt to the core |
| state_o | output | 4 | Current sequencer state |
| done_o | output | 1 | One-cycle pulse when exit completes |

## Verification
Two functions of this block can fall in the same cycle: latching a wakeup, and the entry sequence stepping toward the fully-off state. A wakeup is therefore pulsed while the block is still draining memory traffic. A correct design must carry that request into the fully-off state, stay there for exactly one cycle, and go straight into oscillator settle. The state scoreboard checks the dwell time and the outputs of every state. A separate run pulses the wakeup in the running state and then checks that the fully-off state holds until a new wakeup arrives.

// File: rtl/pms_pkg.sv
// Shared types for the deep low-power sequencer.
// Assumes a 4-bit state code that is visible on the status port.
package pms_pkg;
    typedef enum logic [3:0] {
        ST_RUN      = 4'd0,
        ST_BUS      = 4'd1,
        ST_MEM      = 4'd2,
        ST_SR_ENT   = 4'd3,
        ST_CLK_MASK = 4'd4,
        ST_PLL_OFF  = 4'd5,
        ST_OSC_OFF  = 4'd6,
        ST_OFF      = 4'd7,
        ST_OSC_WAIT = 4'd8,
        ST_PLL_WAIT = 4'd9,
        ST_CLK_ON   = 4'd10,
        ST_SR_EXIT  = 4'd11
    } pms_state_e;

    localparam logic [1:0] STANDBY_DEEP = 2'b10;
endpackage

// File: rtl/pms_wait_ctr.sv
// Down-counter for the settle and lock waits.
// Loads val_i on load_i, then counts down to zero and holds there.
// Assumes it runs on the always-on clock.
module pms_wait_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // load or decrement the wait count
    always_ff @(posedge clk_i) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (load_i)        cnt_q <= val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end

    assign zero_o = (cnt_q == '0);

    // R7
    load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> cnt_q == $past(val_i));

    // R8
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
endmodule

// File: rtl/pms_wake_latch.sv
// Holds a wakeup seen during entry until the fully-off state uses it.
// clr_i is high in the running and fully-off states.
module pms_wake_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wake_i,
    input  logic clr_i,
    output logic hit_o
);
    logic pend_q;

    // remember a wakeup outside the running / off states
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     pend_q <= 1'b0;
        else if (clr_i)  pend_q <= 1'b0;
        else if (wake_i) pend_q <= 1'b1;
    end

    assign hit_o = wake_i | pend_q;

    // R6
    wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_i && !clr_i) |=> pend_q);
endmodule

// File: rtl/pms_fsm.sv
// Entry/exit ordering state machine for the deep low-power mode.
// Moore outputs; handshake steps wait on their acknowledge inputs.
// The domain-power options are latched when entry starts.
module pms_fsm
    import pms_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wfi_i,
    input  logic [1:0] standby_i,
    input  logic       core_on_i,
    input  logic       top_on_i,
    input  logic       l2_keep_i,
    input  logic       bus_idle_i,
    input  logic       mem_idle_i,
    input  logic       sr_ack_i,
    input  logic       wake_hit_i,
    input  logic       ctr_zero_i,
    output logic       ctr_load_o,
    output logic       ctr_sel_pll_o,
    output pms_state_e state_o,
    output logic       osc_en_o,
    output logic       pll_en_o,
    output logic       clk_mask_o,
    output logic       sr_req_o,
    output logic       core_pwr_o,
    output logic       top_pwr_o,
    output logic       l2_pwr_o,
    output logic       done_o
);
    pms_state_e st_q, st_d;
    logic       keep_top_q, keep_l2_q, done_q;
    logic       enter;

    assign enter = wfi_i && (standby_i == STANDBY_DEEP) && !core_on_i;

    // next-state and wait-counter load decode
    always_comb begin
        st_d          = st_q;
        ctr_load_o    = 1'b0;
        ctr_sel_pll_o = 1'b0;
        case (st_q)
            ST_RUN:      if (enter)      st_d = ST_BUS;
            ST_BUS:      if (bus_idle_i) st_d = ST_MEM;
            ST_MEM:      if (mem_idle_i) st_d = ST_SR_ENT;
            ST_SR_ENT:   if (sr_ack_i)   st_d = ST_CLK_MASK;
            ST_CLK_MASK: st_d = ST_PLL_OFF;
            ST_PLL_OFF:  st_d = ST_OSC_OFF;
            ST_OSC_OFF:  st_d = ST_OFF;
            ST_OFF: if (wake_hit_i) begin
                st_d       = ST_OSC_WAIT;
                ctr_load_o = 1'b1;
            end
            ST_OSC_WAIT: if (ctr_zero_i) begin
                st_d          = ST_PLL_WAIT;
                ctr_load_o    = 1'b1;
                ctr_sel_pll_o = 1'b1;
            end
            ST_PLL_WAIT: if (ctr_zero_i) st_d = ST_CLK_ON;
            ST_CLK_ON:   st_d = ST_SR_EXIT;
            ST_SR_EXIT:  if (!sr_ack_i)  st_d = ST_RUN;
            default:     st_d = ST_RUN;
        endcase
    end

    // state, latched power options and done pulse
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q       <= ST_RUN;
            keep_top_q <= 1'b1;
            keep_l2_q  <= 1'b1;
            done_q     <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == ST_SR_EXIT) && !sr_ack_i;
            if (st_q == ST_RUN && enter) begin
                keep_top_q <= top_on_i;
                keep_l2_q  <= l2_keep_i;
            end
        end
    end

    // output decode per state
    always_comb begin
        osc_en_o   = 1'b1;
        pll_en_o   = 1'b1;
        clk_mask_o = 1'b0;
        sr_req_o   = 1'b0;
        core_pwr_o = 1'b1;
        top_pwr_o  = 1'b1;
        l2_pwr_o   = 1'b1;
        case (st_q)
            ST_SR_ENT, ST_CLK_ON: sr_req_o = 1'b1;
            ST_CLK_MASK: begin
                sr_req_o = 1'b1; clk_mask_o = 1'b1;
            end
            ST_PLL_OFF, ST_OSC_WAIT: begin
                sr_req_o = 1'b1; clk_mask_o = 1'b1; pll_en_o = 1'b0;
            end
            ST_OSC_OFF: begin
                sr_req_o = 1'b1; clk_mask_o = 1'b1; pll_en_o = 1'b0;
                osc_en_o = 1'b0;
            end
            ST_OFF: begin
                sr_req_o = 1'b1; clk_mask_o = 1'b1; pll_en_o = 1'b0;
                osc_en_o = 1'b0; core_pwr_o = 1'b0;
                top_pwr_o = keep_top_q; l2_pwr_o = keep_l2_q;
            end
            ST_PLL_WAIT: begin
                sr_req_o = 1'b1; clk_mask_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = st_q;
    assign done_o  = done_q;

    // R1
    stay_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_RUN && !enter) |=> st_q == ST_RUN);

    // R2
    bus_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_BUS && !bus_idle_i) |=> st_q == ST_BUS);

    // R3
    mask_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q == ST_CLK_MASK |=> st_q == ST_PLL_OFF);

    // R5
    off_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_OFF && wake_hit_i) |=> st_q == ST_OSC_WAIT);

    // R9
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_SR_EXIT && !sr_ack_i) |=> (st_q == ST_RUN && done_o));
endmodule

// File: rtl/pms_top.sv
// Deep low-power mode sequencer top.
// Wires the ordering FSM, a shared wait counter and the wakeup latch,
// and gates the interrupt while a sequence runs.
// Assumes clk_i is the always-on clock.
module pms_top
    import pms_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wfi_i,
    input  logic [1:0]       cfg_standby_i,
    input  logic             cfg_core_on_i,
    input  logic             cfg_top_on_i,
    input  logic             cfg_l2_keep_i,
    input  logic             cfg_irq_block_i,
    input  logic             irq_i,
    input  logic             bus_idle_i,
    input  logic             mem_idle_i,
    input  logic             sr_ack_i,
    input  logic             wake_i,
    input  logic [CNT_W-1:0] osc_cnt_i,
    input  logic [CNT_W-1:0] pll_cnt_i,
    output logic             osc_en_o,
    output logic             osc32k_en_o,
    output logic             pll_en_o,
    output logic             clk_mask_o,
    output logic             sr_req_o,
    output logic             core_pwr_o,
    output logic             top_pwr_o,
    output logic             l2_pwr_o,
    output logic             irq_o,
    output logic [3:0]       state_o,
    output logic             done_o
);
    pms_state_e       st;
    logic             ctr_load, ctr_sel_pll, ctr_zero, wake_hit, wake_clr;
    logic [CNT_W-1:0] ctr_val;

    assign ctr_val  = ctr_sel_pll ? pll_cnt_i : osc_cnt_i;
    assign wake_clr = (st == ST_RUN) || (st == ST_OFF);

    pms_wake_latch u_wake (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .wake_i(wake_i),
        .clr_i (wake_clr),
        .hit_o (wake_hit)
    );

    pms_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(ctr_load),
        .val_i (ctr_val),
        .zero_o(ctr_zero)
    );

    pms_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wfi_i        (wfi_i),
        .standby_i    (cfg_standby_i),
        .core_on_i    (cfg_core_on_i),
        .top_on_i     (cfg_top_on_i),
        .l2_keep_i    (cfg_l2_keep_i),
        .bus_idle_i   (bus_idle_i),
        .mem_idle_i   (mem_idle_i),
        .sr_ack_i     (sr_ack_i),
        .wake_hit_i   (wake_hit),
        .ctr_zero_i   (ctr_zero),
        .ctr_load_o   (ctr_load),
        .ctr_sel_pll_o(ctr_sel_pll),
        .state_o      (st),
        .osc_en_o     (osc_en_o),
        .pll_en_o     (pll_en_o),
        .clk_mask_o   (clk_mask_o),
        .sr_req_o     (sr_req_o),
        .core_pwr_o   (core_pwr_o),
        .top_pwr_o    (top_pwr_o),
        .l2_pwr_o     (l2_pwr_o),
        .done_o       (done_o)
    );

    assign osc32k_en_o = 1'b1;
    assign irq_o       = irq_i && !(cfg_irq_block_i && st != ST_RUN);
    assign state_o     = st;

    // R10
    irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> irq_i);
endmodule

// File: tb/pms_top_test.sv
`timescale 1ns/1ps
module pms_top_test;
    localparam int CW = 16;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          wfi = 0, core_on = 0, top_on = 1, l2_keep = 1;
    logic          irq_blk = 0, irq = 0;
    logic          bus_idle = 0, mem_idle = 0, sr_ack = 0, wake = 0;
    logic [1:0]    standby = 2'b00;
    logic [CW-1:0] osc_cnt = '0, pll_cnt = '0;
    logic          osc_en, osc32k_en, pll_en, clk_mask, sr_req;
    logic          core_pwr, top_pwr, l2_pwr, irq_out, done;
    logic [3:0]    state;

    int n_tests = 0, n_fail = 0;

    // scoreboard queues: expected {state, outputs} and dwell (0 = any)
    logic [10:0] exp_q[$];
    int          dwell_q[$];

    always #2 clk = ~clk;

    pms_top #(.CNT_W(CW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .cfg_standby_i(standby),
        .cfg_core_on_i(core_on), .cfg_top_on_i(top_on),
        .cfg_l2_keep_i(l2_keep), .cfg_irq_block_i(irq_blk), .irq_i(irq),
        .bus_idle_i(bus_idle), .mem_idle_i(mem_idle), .sr_ack_i(sr_ack),
        .wake_i(wake), .osc_cnt_i(osc_cnt), .pll_cnt_i(pll_cnt),
        .osc_en_o(osc_en), .osc32k_en_o(osc32k_en), .pll_en_o(pll_en),
        .clk_mask_o(clk_mask), .sr_req_o(sr_req), .core_pwr_o(core_pwr),
        .top_pwr_o(top_pwr), .l2_pwr_o(l2_pwr), .irq_o(irq_out),
        .state_o(state), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected {osc,pll,mask,sr,core,top,l2} per state, from R3/R4/R7-R9
    function automatic logic [6:0] outs_for(input int s, input bit k, input bit l);
        case (s)
            3, 10:   return 7'b1101111;
            4:       return 7'b1111111;
            5, 8:    return 7'b1011111;
            6:       return 7'b0011111;
            7:       return {5'b00110, k, l};
            9:       return 7'b1111111;
            default: return 7'b1100111;
        endcase
    endfunction

    function automatic logic [6:0] outs_now();
        return {osc_en, pll_en, clk_mask, sr_req, core_pwr, top_pwr, l2_pwr};
    endfunction

    // monitor: pop and compare on every state change (R3 R4 R7 R8 R11)
    int  cur_dwell = 0, dwell_cnt = 0;
    logic [3:0] prev_st = 4'd0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (state != prev_st) begin
                if (cur_dwell != 0)
                    check(dwell_cnt == cur_dwell, "R7/R8/R3/R6 dwell", dwell_cnt, cur_dwell);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected state", int'(state), -1);
                    cur_dwell = 0;
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    cur_dwell = dwell_q.pop_front();
                    check({state, outs_now()} == e, "R11/R4 state+outs",
                          int'({state, outs_now()}), int'(e));
                end
                dwell_cnt = 1;
                prev_st = state;
            end else begin
                dwell_cnt++;
            end
        end
    end

    // driver: one full sleep/wake round trip
    task automatic do_sleep(input int n_osc, input int n_pll, input bit k,
                            input bit l, input bit early);
        for (int s = 1; s <= 12; s++) begin
            int st = (s == 12) ? 0 : s;
            int d  = 0;
            if (st >= 4 && st <= 6) d = 1;
            if (st == 7 && early)   d = 1;
            if (st == 8)            d = n_osc + 1;
            if (st == 9)            d = n_pll + 1;
            if (st == 10)           d = 1;
            exp_q.push_back({st[3:0], outs_for(st, k, l)});
            dwell_q.push_back(d);
        end
        osc_cnt = CW'(n_osc); pll_cnt = CW'(n_pll);
        top_on = k; l2_keep = l; standby = 2'b10; core_on = 0;
        wfi = 1; bus_idle = 0; mem_idle = 0;
        @(negedge clk);
        wfi = 0; top_on = !k; l2_keep = !l;   // R4: late changes ignored
        repeat (2) @(negedge clk);
        check(state == 4'd1, "R2 bus drain hold", state, 1);
        irq = 1; irq_blk = 1; #1;
        check(irq_out == 1'b0, "R10 blocked", irq_out, 0);
        irq_blk = 0; #1;
        check(irq_out == 1'b1, "R10 unblocked", irq_out, 1);
        irq = 0;
        bus_idle = 1;
        @(negedge clk);
        if (early) wake = 1;                  // R6: wake during entry
        @(negedge clk);
        wake = 0;
        check(state == 4'd2, "R2 mem drain hold", state, 2);
        mem_idle = 1;
        repeat (3) @(negedge clk);
        check(state == 4'd3, "R2 self-refresh ack hold", state, 3);
        sr_ack = 1;
        if (!early) begin
            while (state != 4'd7) @(negedge clk);
            repeat (3) @(negedge clk);
            check(state == 4'd7, "R5 off hold", state, 7);
            wake = 1;
            @(negedge clk);
            wake = 0;
        end
        while (state != 4'd11) @(negedge clk);
        repeat (2) @(negedge clk);
        check(state == 4'd11, "R9 wait ack low", state, 11);
        sr_ack = 0;
        @(negedge clk);
        check(state == 4'd0 && done, "R9 done rise", int'({state, done}), 1);
        @(negedge clk);
        check(!done, "R9 done one cycle", done, 0);
        bus_idle = 0; mem_idle = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(state == 4'd0, "R12 reset state", state, 0);
        check(outs_now() == 7'b1100111 && osc32k_en, "R12 reset outputs",
              int'(outs_now()), 'b1100111);
        check(!done, "R12 done low", done, 0);
        standby = 2'b01; wfi = 1;
        repeat (2) @(negedge clk);
        check(state == 4'd0, "R1 wrong standby", state, 0);
        standby = 2'b10; core_on = 1;
        repeat (2) @(negedge clk);
        check(state == 4'd0, "R1 core kept on", state, 0);
        wfi = 0; core_on = 0;
        irq = 1; irq_blk = 1; #1;
        check(irq_out == 1'b1, "R10 run passes", irq_out, 1);
        irq = 0; irq_blk = 0;
        wake = 1;                             // R5: ignored in run
        @(negedge clk);
        wake = 0;
        @(negedge clk);
        do_sleep(5, 3, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        do_sleep(0, 0, 1'b0, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        do_sleep(20, 7, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check(osc32k_en, "R3 32k always on", osc32k_en, 1);
        check(exp_q.size() == 0, "R11 all states seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule